// File: doc/BRIEF.md
# I2C Controller Status and Interrupt Register

This block holds the 32-bit status word of an I2C controller. The controller's shift and arbitration engine raises one-cycle event pulses: no acknowledge seen, NAK driven, address hit, general call, byte received, byte sent and arbitration lost. The block turns each pulse into a sticky status flag. Software reads the word and clears individual flags by writing ones to them.

The block also watches the bus itself. It samples SCL and SDA through two-flop synchronizers and decodes START and STOP conditions from them. From these it tracks whether the bus is occupied by another master and whether the unit itself is taking part in a transfer. Per-bit interrupt enables are gated with the sticky flags to form a single interrupt line.

The reset input is asynchronous and active low. It must already be released synchronously to `clk` before it reaches this block.

Top module: `i2c_stat_irq`

## Requirements
- R1: After reset every bit of `rd_data` is 0. Bits 31..11 always read 0.
- R2: Bit 10 (bus error) sets on `ev_mt_noack` or `ev_sr_nak`. It holds until a write with `wr_data[10]`=1, and no other write clears it.
- R3: Bit 9 (address hit) sets on `ev_addr_hit` or `ev_gcall` and is cleared by writing 1. Bit 8 (general call) sets on `ev_gcall`. Bit 8 ignores writes and clears on the next detected START.
- R4: Bit 7 (receive full), bit 6 (transmit empty) and bit 5 (arbitration lost) set on `ev_rx_full`, `ev_tx_done` and `ev_arb_lost` respectively. Each is cleared by writing 1 to its own position.
- R5: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high, both judged on synchronized copies. Bit 3 (bus busy) is 1 between a START and a STOP while the unit is not involved, and 0 otherwise.
- R6: Bit 2 (unit busy) sets when a START is detected after an `own_start` pulse. It also sets when `ev_addr_hit` or `ev_gcall` occurs while the bus is occupied. A STOP clears it. While bit 2 is 1, bit 3 is 0.
- R7: Bit 4 (slave STOP) sets when a STOP is detected while `slave_mode` is 1, and is cleared by writing 1. A STOP with `slave_mode`=0 leaves it at 0.
- R8: Bits 1 and 0 show `ack_in` and `rw_in` as sampled on the previous clock edge. Writes have no effect on them.
- R9: When a set event and a write-1 clear reach the same bit in the same cycle, the bit ends up 1.
- R10: `irq` is 1 exactly when some bit in positions 10, 9, 7, 6, 5 or 4 of `rd_data` is 1 together with the same bit of `int_en`. Other `int_en` bits have no effect.
- R11: An event pulse sampled on a clock edge is visible in `rd_data` immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| own_start | input | 1 | Pulse: the unit is about to issue a START |
| slave_mode | input | 1 | Unit is in slave receive or slave transmit mode |
| ev_mt_noack | input | 1 | Pulse: master transmitter saw no ACK |
| ev_sr_nak | input | 1 | Pulse: slave receiver drove a NAK |
| ev_addr_hit | input | 1 | Pulse: received address matched the own address |
| ev_gcall | input | 1 | Pulse: received address was the general call |
| ev_rx_full | input | 1 | Pulse: new byte received into the data buffer |
| ev_tx_done | input | 1 | Pulse: data byte finished transmitting |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| ack_in | input | 1 | ACK/NAK status of the last byte |
| rw_in | input | 1 | Direction of the current transfer |
| int_en | input | 32 | Interrupt enables, bit-aligned with the status word |
| wr_en | input | 1 | Write strobe for the write-1-to-clear access |
| wr_data | input | 32 | Write data; ones clear the matching sticky flags |
| rd_data | output | 32 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that the reserved bits stay zero and that bus busy and unit busy are never both 1. They also check that a sticky flag that is not being cleared stays set, that a set racing a clear leaves the flag set, that an event shows up in the very next cycle, and that `irq` stays low when no enabled flag is set.

Only the bench's scenarios can show the bus-level behaviour: a foreign transaction raising bus busy, an own START raising unit busy instead, a slave STOP being flagged, general call clearing on a later START, and ignored writes to the read-only bits. A randomized run with a bench model covers arbitrary mixes of events, clears and enables.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int STAT_W   = 32;
  localparam int N_STICKY = 6;

  localparam int B_BERR  = 10;
  localparam int B_SAD   = 9;
  localparam int B_GCALL = 8;
  localparam int B_RXF   = 7;
  localparam int B_TXE   = 6;
  localparam int B_ARB   = 5;
  localparam int B_SSTOP = 4;
  localparam int B_BBUSY = 3;
  localparam int B_UBUSY = 2;
  localparam int B_ACK   = 1;
  localparam int B_RW    = 0;
  localparam int USED_W  = B_BERR + 1;

  // Bit position of each write-1-to-clear flag, indexed by sticky slot
  localparam int STICKY_POS [N_STICKY] = '{B_SSTOP, B_ARB, B_TXE, B_RXF, B_SAD, B_BERR};

  localparam logic [STAT_W-1:0] IRQ_MASK =
    (STAT_W'(1) << B_BERR) | (STAT_W'(1) << B_SAD) | (STAT_W'(1) << B_RXF) |
    (STAT_W'(1) << B_TXE)  | (STAT_W'(1) << B_ARB) | (STAT_W'(1) << B_SSTOP);
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout
);
  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], din[l]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= chain_d;
    end

    assign dout[l] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  input  logic own_start,
  input  logic addr_hit,
  output logic start_det,
  output logic stop_det,
  output logic bus_active,
  output logic unit_busy
);
  logic scl_q, sda_q;
  logic act_q, act_d;
  logic own_q, own_d;
  logic pend_q, pend_d;

  always_comb begin
    start_det = scl_s & scl_q & sda_q & ~sda_s;
    stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  end

  always_comb begin
    act_d  = act_q;
    own_d  = own_q;
    pend_d = pend_q | own_start;
    if (stop_det) begin
      act_d = 1'b0;
      own_d = 1'b0;
    end else if (start_det) begin
      act_d  = 1'b1;
      pend_d = 1'b0;
      if (pend_q | own_start) own_d = 1'b1;
    end else if (addr_hit && act_q) begin
      own_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      act_q  <= 1'b0;
      own_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      scl_q  <= scl_s;
      sda_q  <= sda_s;
      act_q  <= act_d;
      own_q  <= own_d;
      pend_q <= pend_d;
    end
  end

  assign bus_active = act_q;
  assign unit_busy  = own_q;
endmodule

// File: rtl/i2c_w1c_bit.sv
module i2c_w1c_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  logic q_d;

  always_comb begin
    q_d = set_i | (q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end
endmodule

// File: rtl/i2c_stat_irq.sv
module i2c_stat_irq
  import i2c_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              own_start,
  input  logic              slave_mode,
  input  logic              ev_mt_noack,
  input  logic              ev_sr_nak,
  input  logic              ev_addr_hit,
  input  logic              ev_gcall,
  input  logic              ev_rx_full,
  input  logic              ev_tx_done,
  input  logic              ev_arb_lost,
  input  logic              ack_in,
  input  logic              rw_in,
  input  logic [STAT_W-1:0] int_en,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] rd_data,
  output logic              irq
);
  logic [1:0] lines_s;
  logic       start_det, stop_det, bus_active, unit_busy;
  logic [N_STICKY-1:0] st_set, st_clr, st_q;
  logic [STAT_W-1:0]   clr_vec;
  logic gc_q, gc_d;
  logic ack_q, rw_q;

  i2c_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .din ({scl_in, sda_in}),
    .dout (lines_s)
  );

  i2c_bus_monitor u_mon (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (lines_s[1]),
    .sda_s      (lines_s[0]),
    .own_start  (own_start),
    .addr_hit   (ev_addr_hit | ev_gcall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .bus_active (bus_active),
    .unit_busy  (unit_busy)
  );

  always_comb begin
    clr_vec = wr_en ? wr_data : '0;
    st_set  = '0;
    st_set[0] = stop_det & slave_mode;
    st_set[1] = ev_arb_lost;
    st_set[2] = ev_tx_done;
    st_set[3] = ev_rx_full;
    st_set[4] = ev_addr_hit | ev_gcall;
    st_set[5] = ev_mt_noack | ev_sr_nak;
  end

  for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
    assign st_clr[g] = clr_vec[STICKY_POS[g]];
    i2c_w1c_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (st_set[g]),
      .clr_i (st_clr[g]),
      .q     (st_q[g])
    );
  end

  always_comb begin
    gc_d = gc_q;
    if (ev_gcall)       gc_d = 1'b1;
    else if (start_det) gc_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gc_q  <= 1'b0;
      ack_q <= 1'b0;
      rw_q  <= 1'b0;
    end else begin
      gc_q  <= gc_d;
      ack_q <= ack_in;
      rw_q  <= rw_in;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < N_STICKY; k++) rd_data[STICKY_POS[k]] = st_q[k];
    rd_data[B_GCALL] = gc_q;
    rd_data[B_BBUSY] = bus_active & ~unit_busy;
    rd_data[B_UBUSY] = unit_busy;
    rd_data[B_ACK]   = ack_q;
    rd_data[B_RW]    = rw_q;
  end

  assign irq = |(rd_data & int_en & IRQ_MASK);

  logic unused_bits;
  assign unused_bits = ^{clr_vec[STAT_W-1:USED_W], clr_vec[B_GCALL], clr_vec[B_BBUSY:0]};
endmodule

// File: rtl/i2c_stat_irq_chk.sv
module i2c_stat_irq_chk
  import i2c_stat_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ev_rx_full,
  input logic              ev_tx_done,
  input logic              ev_mt_noack,
  input logic [STAT_W-1:0] int_en,
  input logic              wr_en,
  input logic [STAT_W-1:0] wr_data,
  input logic [STAT_W-1:0] rd_data,
  input logic              irq
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[STAT_W-1:USED_W] == '0); // R1

  AST_BERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[B_BERR] && !(wr_en && wr_data[B_BERR]) |=> rd_data[B_BERR]); // R2

  AST_BERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mt_noack |=> rd_data[B_BERR]); // R2

  AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_data[B_BBUSY] && rd_data[B_UBUSY])); // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_done && wr_en && wr_data[B_TXE] |=> rd_data[B_TXE]); // R9

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data & int_en & IRQ_MASK) == '0) |-> !irq); // R10

  AST_EVT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_full |=> rd_data[B_RXF]); // R11
endmodule

bind i2c_stat_irq i2c_stat_irq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_rx_full  (ev_rx_full),
  .ev_tx_done  (ev_tx_done),
  .ev_mt_noack (ev_mt_noack),
  .int_en      (int_en),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .rd_data     (rd_data),
  .irq         (irq)
);

// File: tb/tb_i2c_stat_irq.sv
module tb_i2c_stat_irq;
  localparam logic [31:0] IRQ_M = 32'h0000_06F0;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_in, sda_in, own_start, slave_mode;
  logic ev_mt_noack, ev_sr_nak, ev_addr_hit, ev_gcall;
  logic ev_rx_full, ev_tx_done, ev_arb_lost, ack_in, rw_in;
  logic [31:0] int_en, wr_data, rd_data;
  logic wr_en, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i2c_stat_irq dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .own_start(own_start), .slave_mode(slave_mode),
    .ev_mt_noack(ev_mt_noack), .ev_sr_nak(ev_sr_nak),
    .ev_addr_hit(ev_addr_hit), .ev_gcall(ev_gcall),
    .ev_rx_full(ev_rx_full), .ev_tx_done(ev_tx_done),
    .ev_arb_lost(ev_arb_lost), .ack_in(ack_in), .rw_in(rw_in),
    .int_en(int_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic idle_inputs();
    own_start = 0; slave_mode = 0; ev_mt_noack = 0; ev_sr_nak = 0;
    ev_addr_hit = 0; ev_gcall = 0; ev_rx_full = 0; ev_tx_done = 0;
    ev_arb_lost = 0; ack_in = 0; rw_in = 0; wr_en = 0; wr_data = '0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    idle_inputs();
    scl_in = 1; sda_in = 1; int_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // Move the bus lines and let the synchronizer and decoder settle
  task automatic lines(input logic scl, input logic sda);
    scl_in = scl; sda_in = sda;
    repeat (5) @(negedge clk);
  endtask

  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  // Bench model of one cycle with idle bus lines
  function automatic logic [31:0] model_next(
      input logic [31:0] cur, input logic [6:0] ev,
      input logic we, input logic [31:0] wd,
      input logic ack, input logic rw);
    logic [31:0] c, n;
    c = we ? wd : '0;
    n = '0;
    n[10] = ev[0] | ev[1] | (cur[10] & ~c[10]);
    n[9]  = ev[2] | ev[3] | (cur[9] & ~c[9]);
    n[8]  = ev[3] | cur[8];
    n[7]  = ev[4] | (cur[7] & ~c[7]);
    n[6]  = ev[5] | (cur[6] & ~c[6]);
    n[5]  = ev[6] | (cur[5] & ~c[5]);
    n[4]  = cur[4] & ~c[4];
    n[1]  = ack;
    n[0]  = rw;
    return n;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp;
    logic [6:0] ev;
    void'($urandom(32'd4242));
    do_reset();
    chk("R1 reset state", rd_data, 32'h0);
    chk("R10 irq after reset", {31'h0, irq}, 32'h0);

    // R11 / R2: event then clear
    ev_mt_noack = 1; step();
    chk("R11 R2 bus error visible next cycle", rd_data, 32'h400);
    wr_en = 1; wr_data = 32'hFFFF_FBFF; step();
    chk("R2 unrelated clear keeps error", rd_data, 32'h400);
    wr_en = 1; wr_data = 32'h400; step();
    chk("R2 write-1 clears error", rd_data, 32'h0);
    ev_sr_nak = 1; step();
    chk("R2 NAK sets error", rd_data[10], 1'b1);
    wr_en = 1; wr_data = 32'h400; step();

    // R4 flags
    ev_rx_full = 1; ev_tx_done = 1; ev_arb_lost = 1; step();
    chk("R4 rx tx arb set", rd_data, 32'h0E0);
    wr_en = 1; wr_data = 32'h040; step();
    chk("R4 clear only tx", rd_data, 32'h0A0);
    wr_en = 1; wr_data = 32'h0A0; step();

    // R9 set beats clear
    ev_rx_full = 1; wr_en = 1; wr_data = 32'h080; step();
    chk("R9 set wins over clear", rd_data, 32'h080);
    wr_en = 1; wr_data = 32'h080; step();

    // R8 ack / rw
    ack_in = 1; rw_in = 1; wr_en = 1; wr_data = 32'h3; @(negedge clk);
    chk("R8 ack rw follow inputs", rd_data, 32'h3);
    idle_inputs(); @(negedge clk);

    // R10 enables
    ev_arb_lost = 1; step();
    int_en = 32'hFFFF_F9DF;
    #1 chk("R10 irq off when bit not enabled", {31'h0, irq}, 32'h0);
    int_en = 32'h0000_0020;
    #1 chk("R10 irq on when enabled", {31'h0, irq}, 32'h1);
    wr_en = 1; wr_data = 32'h20; step();
    chk("R10 irq drops after clear", {31'h0, irq}, 32'h0);
    int_en = '0;

    // R5 foreign transaction
    lines(1, 0);
    chk("R5 foreign START sets bus busy", rd_data, 32'h008);
    lines(0, 0); lines(1, 0); lines(1, 1);
    chk("R5 STOP clears bus busy", rd_data, 32'h000);
    chk("R7 master STOP no slave flag", rd_data[4], 1'b0);

    // R6 own transaction
    own_start = 1; step();
    lines(1, 0);
    chk("R6 own START sets unit busy only", rd_data, 32'h004);
    slave_mode = 1;
    lines(0, 0); lines(1, 0); lines(1, 1);
    chk("R6 R7 STOP clears unit busy, slave stop set", rd_data, 32'h010);
    wr_en = 1; wr_data = 32'h10; step();
    chk("R7 slave stop cleared", rd_data, 32'h000);

    // R3 general call, R6 address hit during foreign bus
    lines(1, 0);
    ev_gcall = 1; step();
    chk("R3 R6 gcall sets 9 8 and unit busy", rd_data, 32'h304);
    wr_en = 1; wr_data = 32'h100; step();
    chk("R3 write ignored on general call bit", rd_data, 32'h304);
    wr_en = 1; wr_data = 32'h200; step();
    chk("R3 address hit cleared", rd_data, 32'h104);
    lines(1, 1);
    lines(1, 0);
    chk("R3 next START clears general call", rd_data, 32'h008);
    lines(1, 1);

    // Random phase
    do_reset();
    exp = '0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      chk("R2-R4 R8-R11 random status", rd_data, exp);
      chk("R10 random irq", {31'h0, irq}, {31'h0, |(exp & int_en & IRQ_M)});
      for (int b = 0; b < 7; b++) ev[b] = ($urandom % 5) == 0;
      {ev_mt_noack, ev_sr_nak, ev_addr_hit, ev_gcall, ev_rx_full, ev_tx_done, ev_arb_lost} =
        {ev[0], ev[1], ev[2], ev[3], ev[4], ev[5], ev[6]};
      ack_in = $urandom % 2; rw_in = $urandom % 2;
      wr_en = ($urandom % 3) == 0;
      wr_data = $urandom;
      if (i % 40 == 0) int_en = $urandom;
      exp = model_next(exp, ev, wr_en, wr_data, ack_in, rw_in);
    end
    @(negedge clk);
    chk("R2 final random status", rd_data, exp);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule